// File: doc/BRIEF.md
# Dual Boost Pulse Timer

This block drives the two high-voltage boost enables of a unipolar two-phase stepper drive. Each phase has its own one-shot. The step sequencer pulses a per-phase change strobe whenever it changes that phase's state. The one-shot then holds its enable high for a fixed number of clock cycles. During that time the winding is connected to the higher supply, so its current rises fast at the start of a step.

Both channels use one shared duration input, counted in clock cycles. At 50 MHz, a nominal 260 µs pulse is 13000 cycles, and the whole 220 to 300 µs band (11000 to 15000 cycles) fits in the 16-bit default width. An abort input cuts both pulses short at once. An inhibit input clears both channels and holds them off. A duration of zero turns boosting off.

Top module: `boost_pulse_timer`

## Requirements
- R1: A strobe on `trig_a` (or `trig_b`), taken at a rising clock edge, raises that channel's enable from the following cycle. The enable stays high for exactly `dur` consecutive cycles and then falls.
- R2: The two channels are independent. A strobe on one channel never changes the other channel's enable, and both channels read the same `dur` value.
- R3: The enables are active high and are low after reset (`rst_n` low, asynchronous).
- R4: A running pulse always ends. Without further strobes, the enable is low after `dur` cycles.
- R5: A strobe on a channel whose pulse is still running restarts it. The enable then stays high for a full `dur` cycles counted from the new strobe.
- R6: `abort` high at a clock edge ends both pulses, so both enables are low in the next cycle. A strobe at the same edge as `abort` is dropped.
- R7: `inhibit` high clears both channels and holds both enables low. Strobes that arrive while `inhibit` is high are ignored and leave no pulse behind after release.
- R8: With `dur` equal to zero, a strobe starts no pulse. A pulse that is already running continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inhibit | input | 1 | Clears and holds both channels off |
| abort | input | 1 | Ends both running pulses at once |
| dur | input | CNT_W | Pulse length in clock cycles, shared by both channels |
| trig_a | input | 1 | Phase A change strobe |
| trig_b | input | 1 | Phase B change strobe |
| boost_a | output | 1 | Phase A boost enable, active high |
| boost_b | output | 1 | Phase B boost enable, active high |

## Verification
The hardest case to reach is a restart in the middle of a pulse. The second strobe has to land while the first pulse is still running, and the bench must then check that the enable never dropped and that the remaining length is counted afresh. The bench fires one strobe, lets two cycles pass, fires again, and then counts the high cycles from the second strobe against `dur`. Abort colliding with a strobe, and inhibit arriving while a pulse runs, are driven on exact negative edges in the same way.

// File: rtl/boost_pulse_timer.sv
module boost_pulse_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inhibit,
  input  logic             abort,
  input  logic [CNT_W-1:0] dur,
  input  logic             trig_a,
  input  logic             trig_b,
  output logic             boost_a,
  output logic             boost_b
);
  logic [CNT_W-1:0] cnt_a, cnt_b;
  logic clear, load_a, load_b;

  assign clear  = inhibit | abort;
  assign load_a = trig_a && (dur != '0);
  assign load_b = trig_b && (dur != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a <= '0;
      cnt_b <= '0;
    end else if (clear) begin
      cnt_a <= '0;
      cnt_b <= '0;
    end else begin
      if (load_a)              cnt_a <= dur;
      else if (cnt_a != '0)    cnt_a <= cnt_a - 1'b1;
      if (load_b)              cnt_b <= dur;
      else if (cnt_b != '0)    cnt_b <= cnt_b - 1'b1;
    end
  end

  assign boost_a = cnt_a != '0;
  assign boost_b = cnt_b != '0;

  a_r1_fire_a: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_a && !inhibit && !abort && dur != '0) |=> boost_a);
  a_r1_fire_b: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_b && !inhibit && !abort && dur != '0) |=> boost_b);
  a_r2_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!boost_b && !trig_b) |=> !boost_b);
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (boost_a && !trig_a && !clear) |=> (cnt_a == $past(cnt_a) - 1'b1));
  a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!boost_a && !boost_b));
  a_r7_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (!boost_a && !boost_b));
  a_r8_zero_dur: assert property (@(posedge clk) disable iff (!rst_n)
    (dur == '0 && !boost_a) |=> !boost_a);
endmodule

// File: tb/sim_boost_pulse_timer.sv
module sim_boost_pulse_timer;
  logic clk = 1'b0, rst_n = 1'b0, inhibit = 1'b0, abort = 1'b0;
  logic trig_a = 1'b0, trig_b = 1'b0;
  logic [15:0] dur = 16'd5;
  logic boost_a, boost_b;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  boost_pulse_timer #(.CNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .abort(abort), .dur(dur),
    .trig_a(trig_a), .trig_b(trig_b), .boost_a(boost_a), .boost_b(boost_b));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fire(input logic ta, input logic tb);
    @(negedge clk); trig_a = ta; trig_b = tb;
    @(negedge clk); trig_a = 1'b0; trig_b = 1'b0;
  endtask

  task automatic measure(output int la, output int lb);
    la = 0; lb = 0;
    for (int i = 0; i < 20000; i++) begin
      if (!boost_a && !boost_b) break;
      if (boost_a) la++;
      if (boost_b) lb++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R3 reset a", boost_a, 0);
    chk("R3 reset b", boost_b, 0);
  endtask

  task automatic t_single;
    int la, lb;
    dur = 16'd5; fire(1, 0); measure(la, lb);
    chk("R1 length a", la, 5); chk("R2 b untouched", lb, 0);
    dur = 16'd7; fire(0, 1); measure(la, lb);
    chk("R1 length b", lb, 7); chk("R2 a untouched", la, 0);
    dur = 16'd1; fire(1, 1); measure(la, lb);
    chk("R4 dur one a", la, 1); chk("R4 dur one b", lb, 1);
  endtask

  task automatic t_nominal;
    int la, lb;
    dur = 16'd13000; fire(1, 1); measure(la, lb);
    chk("R4 nominal a", la, 13000); chk("R2 shared dur b", lb, 13000);
  endtask

  task automatic t_restart;
    int la, lb;
    dur = 16'd6; fire(1, 0);
    @(negedge clk); chk("R5 still high", boost_a, 1);
    trig_a = 1'b1;
    @(negedge clk); trig_a = 1'b0;
    chk("R5 no gap", boost_a, 1);
    measure(la, lb);
    chk("R5 full length after restart", la, 6);
  endtask

  task automatic t_abort;
    int la, lb;
    dur = 16'd10; fire(1, 1);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk("R6 abort a", boost_a, 0); chk("R6 abort b", boost_b, 0);
    @(negedge clk); chk("R6 stays low", boost_a | boost_b, 0);
    trig_a = 1'b1; abort = 1'b1;
    @(negedge clk); trig_a = 1'b0; abort = 1'b0;
    chk("R6 strobe dropped", boost_a, 0);
    measure(la, lb);
  endtask

  task automatic t_inhibit;
    dur = 16'd8; inhibit = 1'b1; fire(1, 1);
    chk("R7 ignored while inhibited", boost_a | boost_b, 0);
    @(negedge clk); inhibit = 1'b0;
    @(negedge clk); chk("R7 nothing after release", boost_a | boost_b, 0);
    fire(1, 1);
    @(negedge clk); inhibit = 1'b1;
    @(negedge clk); chk("R7 clears running", boost_a | boost_b, 0);
    inhibit = 1'b0;
    @(negedge clk); chk("R7 stays cleared", boost_a | boost_b, 0);
  endtask

  task automatic t_zero;
    int la, lb;
    dur = 16'd0; fire(1, 1);
    chk("R8 zero dur a", boost_a, 0); chk("R8 zero dur b", boost_b, 0);
    dur = 16'd6; fire(1, 0);
    @(negedge clk); dur = 16'd0; trig_a = 1'b1;
    @(negedge clk); trig_a = 1'b0;
    measure(la, lb);
    chk("R8 running pulse continues", la, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_restart();
    t_abort();
    t_inhibit();
    t_zero();
    t_nominal();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule